// File: doc/BRIEF.md
# Trace Resource Event Selector

This block turns the outputs of a trace unit's resource logic into up to four event element pulses. A 64-bit control word holds one small configuration slot for each event. Each slot does one of two things. It points at one of 32 single resource selector outputs, or it points at one of 16 Boolean-combined selector pair outputs. On every clock the block looks at the chosen input for each slot. It gates that input with the slot's bit in a 4-bit instruction-trace enable mask and with a pause flag, and registers the result as a one-cycle event pulse.

Software programs the control word through a simple write port while the trace unit is idle. Writes made at any other time are dropped. The word can be read back at any time, with every reserved position read as zero. Parameters set how many slots are built (1 to 4) and how many single selectors and pairs exist. Any selection that points outside what exists, and the meaningless pair index zero, never fires. This keeps the output deterministic.

Top module: `trc_evsel`

## Requirements
- R1: After reset the control word reads all zero and every event output is low.
- R2: Reads return zero in bits 63:32 and in bits 8n+6 and 8n+5 of every slot, whatever was written there.
- R3: Slot n stores a mode bit at bit 8n+7 and a 5-bit index at bits 8n+4..8n. With the mode bit 0, the index selects resource status bit 0..31. The event for slot n rises one clock after that status bit is seen high.
- R4: With the mode bit 1, index bits 3..0 select pair status bit 0..15 and the single-resource vector has no effect. Index bit 4 is stored as zero and reads back as zero.
- R5: Event output n is high only if enable mask bit n was high in the cycle the resource was sampled.
- R6: Pair index 0, a single index at or above NUM_SINGLE, and a pair index at or above NUM_PAIR never fire.
- R7: While the pause input is high, every event output in the following cycle is low.
- R8: A write presented while the idle input is low leaves the control word unchanged.
- R9: Slots at or above NUM_SLOTS read as zero and their event outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | 64 | Write data |
| cfg_rd_data | output | 64 | Current control word, reserved bits zero |
| unit_idle | input | 1 | Trace unit is idle; writes accepted only when high |
| rsrc_paused | input | 1 | Resources paused; suppresses all events |
| rsrc_status | input | 32 | Single resource selector outputs |
| pair_status | input | 16 | Combined selector pair outputs |
| inst_en | input | 4 | Per-event instruction-trace enable mask |
| evt_out | output | 4 | Registered event element pulses |

## Verification
Every result here is due one clock after its cause. Event outputs reflect the resource, pair, enable and pause inputs sampled at the previous rising edge. The control word seen on the read port shows a write one edge after the strobe, and a new configuration first steers events at the edge after that. The bench changes inputs on falling edges and compares both outputs at the next falling edge. It checks them against a model that updates its own copy of the word and its expected events at each rising edge, so each comparison lands exactly one register stage after the stimulus.

// File: rtl/evsel_pkg.sv
package evsel_pkg;
  localparam int REG_W    = 64;
  localparam int SLOT_MAX = 4;
  localparam int STRIDE   = 8;
  localparam int IDX_W    = 5;
  localparam int PIDX_W   = 4;
  localparam int RES_W    = 32;
  localparam int PAIR_W   = 16;
  localparam int MODE_POS = 7;

  typedef struct packed {
    logic             pair_mode;
    logic [IDX_W-1:0] idx;
  } slot_cfg_t;

  // Clean one written byte: drop reserved bits, clear idx[4] in pair mode.
  function automatic slot_cfg_t legalize(input logic [STRIDE-1:0] b);
    slot_cfg_t c;
    c.pair_mode = b[MODE_POS];
    c.idx       = b[MODE_POS] ? {1'b0, b[PIDX_W-1:0]} : b[IDX_W-1:0];
    return c;
  endfunction

  function automatic logic [STRIDE-1:0] to_byte(input slot_cfg_t c);
    return {c.pair_mode, {(STRIDE-IDX_W-1){1'b0}}, c.idx};
  endfunction

  // Bits that must read zero inside one slot byte.
  function automatic logic [STRIDE-1:0] rsvd_mask();
    logic [STRIDE-1:0] m;
    m = '1;
    m[MODE_POS] = 1'b0;
    m[IDX_W-1:0] = '0;
    return m;
  endfunction
endpackage

// File: rtl/evsel_cfg_reg.sv
module evsel_cfg_reg
  import evsel_pkg::*;
#(
  parameter int NUM_SLOTS = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [REG_W-1:0]              wr_data,
  input  logic                          idle,
  output slot_cfg_t [SLOT_MAX-1:0]      cfg_o,
  output logic [REG_W-1:0]              rd_data,
  output logic                          wr_accept,
  output logic                          rsvd_wr_seen
);
  localparam int LIVE_BITS = SLOT_MAX * STRIDE;

  assign wr_accept = wr_en && idle;

  logic [SLOT_MAX-1:0] rsvd_hit;

  for (genvar n = 0; n < SLOT_MAX; n++) begin : g_slot
    if (n < NUM_SLOTS) begin : g_live
      slot_cfg_t q;
      always_ff @(posedge clk) begin
        if (!rst_n)         q <= '0;
        else if (wr_accept) q <= legalize(wr_data[n*STRIDE +: STRIDE]);
      end
      assign cfg_o[n] = q;
      assign rd_data[n*STRIDE +: STRIDE] = to_byte(q);
      assign rsvd_hit[n] = |(wr_data[n*STRIDE +: STRIDE] & rsvd_mask());
    end else begin : g_dead
      assign cfg_o[n] = '0;
      assign rd_data[n*STRIDE +: STRIDE] = '0;
      assign rsvd_hit[n] = |wr_data[n*STRIDE +: STRIDE];
    end
  end

  assign rd_data[REG_W-1:LIVE_BITS] = '0;

  // Write attempt carrying ones in positions that must read zero.
  assign rsvd_wr_seen = wr_accept && ((|rsvd_hit) || (|wr_data[REG_W-1:LIVE_BITS]));
endmodule

// File: rtl/evsel_slot.sv
module evsel_slot
  import evsel_pkg::*;
#(
  parameter int NUM_SINGLE = 28,
  parameter int NUM_PAIR   = 12
) (
  input  slot_cfg_t          cfg,
  input  logic [RES_W-1:0]   rsrc,
  input  logic [PAIR_W-1:0]  pair,
  output logic               legal,
  output logic               hit
);
  logic [PIDX_W-1:0] pidx;
  assign pidx = cfg.idx[PIDX_W-1:0];

  always_comb begin
    if (cfg.pair_mode)
      legal = (pidx != '0) && (int'(pidx) < NUM_PAIR);
    else
      legal = int'(cfg.idx) < NUM_SINGLE;
  end

  assign hit = legal && (cfg.pair_mode ? pair[pidx] : rsrc[cfg.idx]);
endmodule

// File: rtl/evsel_event_reg.sv
module evsel_event_reg
  import evsel_pkg::*;
#(
  parameter int NUM_SLOTS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SLOT_MAX-1:0] hit,
  input  logic [SLOT_MAX-1:0] en,
  input  logic                paused,
  output logic [SLOT_MAX-1:0] evt
);
  localparam logic [SLOT_MAX-1:0] LIVE_MASK = SLOT_MAX'((1 << NUM_SLOTS) - 1);

  logic [SLOT_MAX-1:0] evt_d;
  assign evt_d = paused ? '0 : (hit & en & LIVE_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) evt <= '0;
    else        evt <= evt_d;
  end
endmodule

// File: rtl/trc_evsel.sv
module trc_evsel
  import evsel_pkg::*;
#(
  parameter int NUM_SLOTS  = 3,
  parameter int NUM_SINGLE = 28,
  parameter int NUM_PAIR   = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [63:0] cfg_wr_data,
  output logic [63:0] cfg_rd_data,
  input  logic        unit_idle,
  input  logic        rsrc_paused,
  input  logic [31:0] rsrc_status,
  input  logic [15:0] pair_status,
  input  logic [3:0]  inst_en,
  output logic [3:0]  evt_out
);
  slot_cfg_t [SLOT_MAX-1:0] slot_cfg;
  logic [SLOT_MAX-1:0]      slot_hit;
  logic [SLOT_MAX-1:0]      slot_legal;
  logic                     wr_accept;
  logic                     rsvd_wr_seen;

  evsel_cfg_reg #(.NUM_SLOTS(NUM_SLOTS)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cfg_wr_en),
    .wr_data      (cfg_wr_data),
    .idle         (unit_idle),
    .cfg_o        (slot_cfg),
    .rd_data      (cfg_rd_data),
    .wr_accept    (wr_accept),
    .rsvd_wr_seen (rsvd_wr_seen)
  );

  for (genvar n = 0; n < SLOT_MAX; n++) begin : g_sel
    evsel_slot #(.NUM_SINGLE(NUM_SINGLE), .NUM_PAIR(NUM_PAIR)) u_slot (
      .cfg   (slot_cfg[n]),
      .rsrc  (rsrc_status),
      .pair  (pair_status),
      .legal (slot_legal[n]),
      .hit   (slot_hit[n])
    );
  end

  evsel_event_reg #(.NUM_SLOTS(NUM_SLOTS)) u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (slot_hit),
    .en     (inst_en),
    .paused (rsrc_paused),
    .evt    (evt_out)
  );
endmodule

// File: rtl/evsel_chk.sv
module evsel_chk #(
  parameter int NUM_SLOTS = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_en,
  input logic        unit_idle,
  input logic        rsrc_paused,
  input logic [3:0]  inst_en,
  input logic [63:0] cfg_rd_data,
  input logic [3:0]  evt_out,
  input logic [3:0]  slot_hit,
  input logic [3:0]  slot_legal,
  input logic        wr_accept,
  input logic        rsvd_wr_seen
);
  localparam logic [3:0]  LIVE_MASK = 4'((1 << NUM_SLOTS) - 1);
  localparam logic [63:0] RSVD_RD   = 64'hFFFF_FFFF_6060_6060;

  // R7: pause empties the next cycle's events
  p_quiet_when_paused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsrc_paused |=> (evt_out == 4'b0));

  // R5: a cleared enable bit blocks its event
  p_enable_gates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_en != 4'hF) |=> ((evt_out & ~$past(inst_en)) == 4'b0));

  // R8: busy writes leave the word untouched
  p_busy_write_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && !unit_idle) |=> $stable(cfg_rd_data));

  // R2: reserved positions written with ones still read zero
  p_rsvd_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_wr_seen |=> ((cfg_rd_data & RSVD_RD) == 64'b0));

  // R3: an event needs a selected, live resource one cycle before
  p_event_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_out) |-> ((evt_out & ~$past(slot_hit)) == 4'b0));

  // R6: illegal selection never produces a hit
  p_illegal_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_hit & ~slot_legal) == 4'b0));

  // R9: absent slots stay silent
  p_dead_slots_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> ##1 ((evt_out & ~LIVE_MASK) == 4'b0));
endmodule

bind trc_evsel evsel_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr_en    (cfg_wr_en),
  .unit_idle    (unit_idle),
  .rsrc_paused  (rsrc_paused),
  .inst_en      (inst_en),
  .cfg_rd_data  (cfg_rd_data),
  .evt_out      (evt_out),
  .slot_hit     (slot_hit),
  .slot_legal   (slot_legal),
  .wr_accept    (wr_accept),
  .rsvd_wr_seen (rsvd_wr_seen)
);

// File: tb/trc_evsel_test.sv
module trc_evsel_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT   = 3;
  localparam int NSINGLE = 28;
  localparam int NPAIR   = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [63:0] cfg_wr_data = '0;
  logic [63:0] cfg_rd_data;
  logic        unit_idle = 1'b1;
  logic        rsrc_paused = 1'b0;
  logic [31:0] rsrc_status = '0;
  logic [15:0] pair_status = '0;
  logic [3:0]  inst_en = 4'hF;
  logic [3:0]  evt_out;

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  trc_evsel #(.NUM_SLOTS(NSLOT), .NUM_SINGLE(NSINGLE), .NUM_PAIR(NPAIR)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .unit_idle(unit_idle), .rsrc_paused(rsrc_paused),
    .rsrc_status(rsrc_status), .pair_status(pair_status), .inst_en(inst_en),
    .evt_out(evt_out)
  );

  // ---------------- behavioural reference ----------------
  logic [63:0] m_word;
  logic [3:0]  m_evt;

  function automatic bit ref_hit(logic [63:0] w, int n, logic [31:0] rs, logic [15:0] pr);
    int sel;
    sel = int'(w[8*n +: 5]);
    if (w[8*n+7]) begin
      int p;
      p = sel % 16;
      return (p != 0) && (p < NPAIR) && pr[p];
    end
    return (sel < NSINGLE) && rs[sel];
  endfunction

  function automatic logic [63:0] ref_store(logic [63:0] d);
    logic [63:0] o;
    o = '0;
    for (int n = 0; n < NSLOT; n++) begin
      if (d[8*n+7]) o[8*n +: 8] = {4'b1000, d[8*n +: 4]};
      else          o[8*n +: 8] = {3'b000, d[8*n +: 5]};
    end
    return o;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_word <= '0;
      m_evt  <= '0;
    end else begin
      logic [3:0] e;
      e = '0;
      for (int n = 0; n < NSLOT; n++)
        e[n] = !rsrc_paused && inst_en[n] && ref_hit(m_word, n, rsrc_status, pair_status);
      m_evt <= e;
      if (cfg_wr_en && unit_idle) m_word <= ref_store(cfg_wr_data);
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check64({cur_req, " word"}, cfg_rd_data, m_word);
    check64({cur_req, " events"}, {60'b0, evt_out}, {60'b0, m_evt});
  endtask

  task automatic wr(logic [63:0] d, logic idle);
    cfg_wr_en = 1'b1; cfg_wr_data = d; unit_idle = idle;
    tick();
    cfg_wr_en = 1'b0; unit_idle = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check64("R1 word", cfg_rd_data, 64'h0);
    check64("R1 events", {60'b0, evt_out}, 64'h0);
    tick();

    // R2 R4 R9: all ones written; only mode + low idx of live slots survive
    cur_req = "R2";
    wr(64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    check64("R2/R4/R9 readback", cfg_rd_data, 64'h0000_0000_008F_8F8F);
    wr(64'hFFFF_FFFF_0065_6565, 1'b1);
    check64("R2 reserved single", cfg_rd_data, 64'h0000_0000_0005_0505);

    // R3: single mode, slot0 idx5, slot1 idx27, slot2 idx0
    cur_req = "R3";
    wr(64'h0000_0000_0000_1B05, 1'b1);
    rsrc_status = 32'h0000_0020;
    tick();
    check64("R3 idx5 fires", {60'b0, evt_out}, 64'h1);
    rsrc_status = 32'h0800_0001;
    tick();
    check64("R3 idx27 and idx0", {60'b0, evt_out}, 64'h6);
    for (int i = 0; i < 20; i++) begin
      rsrc_status = $urandom;
      tick();
    end

    // R4: pair mode, idx4 set on slot0 is dropped
    cur_req = "R4";
    rsrc_status = '1;
    wr(64'h0000_0000_0081_8B93, 1'b1);
    check64("R4 readback", cfg_rd_data, 64'h0000_0000_0081_8B83);
    pair_status = 16'h0808;
    tick();
    check64("R4 pairs 3 and 11", {60'b0, evt_out}, 64'h3);
    for (int i = 0; i < 20; i++) begin
      pair_status = 16'($urandom);
      rsrc_status = $urandom;
      tick();
    end

    // R6: single 30, pair 0, pair 12 are all out of range
    cur_req = "R6";
    wr(64'h0000_0000_008C_801E, 1'b1);
    rsrc_status = '1; pair_status = '1;
    tick();
    check64("R6 illegal silent", {60'b0, evt_out}, 64'h0);

    // R5 R9: enable mask gating
    cur_req = "R5";
    wr(64'h0000_0000_0003_0201, 1'b1);
    inst_en = 4'b0101;
    tick();
    check64("R5 mask 0101", {60'b0, evt_out}, 64'h5);
    inst_en = 4'b1010;
    tick();
    check64("R5/R9 mask 1010", {60'b0, evt_out}, 64'h2);
    inst_en = 4'hF;

    // R7: pause
    cur_req = "R7";
    rsrc_paused = 1'b1;
    tick();
    check64("R7 paused", {60'b0, evt_out}, 64'h0);
    rsrc_paused = 1'b0;
    tick();
    check64("R7 resumed", {60'b0, evt_out}, 64'h7);

    // R8: busy write dropped
    cur_req = "R8";
    wr(64'h0, 1'b0);
    check64("R8 word kept", cfg_rd_data, 64'h0000_0000_0003_0201);
    tick();
    check64("R8 events kept", {60'b0, evt_out}, 64'h7);

    // mixed random traffic against the model
    cur_req = "R3/R4/R5/R6/R7/R8";
    for (int i = 0; i < 400; i++) begin
      cfg_wr_en   = ($urandom % 6) == 0;
      cfg_wr_data = {$urandom, $urandom};
      unit_idle   = ($urandom % 3) != 0;
      rsrc_paused = ($urandom % 8) == 0;
      rsrc_status = $urandom;
      pair_status = 16'($urandom);
      inst_en     = 4'($urandom);
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule